// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block watches the eight inputs of one GPIO port, already synchronized to the core clock, and latches an event bit for each pin when that pin meets its configured trigger condition. Each pin has its own trigger condition. It can be a rising edge, a falling edge, either edge, a high level or a low level. Software clears the latched bits through a dedicated write-one-to-clear register. A single port interrupt line is raised when any latched bit is also enabled.

The trigger configuration is held as three byte lanes. The low lane selects polarity or the active level. The middle lane selects edge detection over level detection. The top lane selects detection on both edges. The enable register and the trigger register each have a masked-write alias, so one pin's setting can be changed without first reading the register. All register addresses move up by four bytes for each step of the port index parameter, so several instances can share one address decoder.

Top module: `gpirq_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the enable, trigger and event registers read zero and `irq` is low.
- R2: A pin with edge=1, polarity=1, both=0 sets its event bit on the clock edge that first samples the pin high after it was low. A falling transition does not set it.
- R3: A pin with edge=1, polarity=0, both=0 sets its event bit only when the pin goes from high to low.
- R4: A pin with edge=1 and both=1 sets its event bit on either transition, whatever its polarity bit holds.
- R5: A pin with edge=0 sets its event bit on every cycle that the pin equals its polarity bit (1 means active high, 0 means active low). A clear therefore has no lasting effect while the level persists.
- R6: Writing the clear register (offset 0x70) clears each event bit whose data bit is 1. Data bits that are 0 leave the event bits unchanged. The clear register reads as zero.
- R7: When a qualifying edge and a clear of the same bit fall in the same cycle, the event bit ends up set.
- R8: Event bits are set whatever the enable bits hold. The enable bits gate only `irq`.
- R9: `irq` is registered. It is high one cycle after any bit of (event AND enable) is 1.
- R10: A write to the enable alias at offset 0xD0 updates only the enable bits whose mask bit (wdata[15:8]) is 1, loading them from wdata[7:0].
- R11: A write to the trigger alias at offset 0xE0 selects a lane with wdata[17:16] (0 polarity, 1 edge, 2 both) and updates that lane's bits under mask wdata[15:8] from value wdata[7:0]. Lane code 3 changes nothing.
- R12: Reads return data one cycle after the address is presented. The offsets are: event register 0x40 (read only, writes ignored), enable 0x50, trigger 0x60. The trigger register holds polarity in bits [7:0], edge in bits [15:8] and both in bits [23:16]. Every offset is increased by 4 times PORT_IDX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | NPIN | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Byte address of the register access |
| wdata | input | 3*NPIN | Write data |
| rdata | output | 3*NPIN | Registered read data |
| irq | output | 1 | Port interrupt request |

## Verification
The assertions assume that `pins_in` is already synchronous to `clk` and that reset is held for at least two clock edges. They also assume that a write strobe lasts one cycle per access, so that every event-bit change can be traced to the set and clear vectors of the preceding cycle. The stimulus changes pins and bus signals only on falling clock edges. It holds reset for four cycles. Before reconfiguring trigger modes it settles the pins and clears the event bits, so the state carried into each sweep step is known.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;
  localparam int unsigned OFS_STAT = 32'h40;
  localparam int unsigned OFS_ENB  = 32'h50;
  localparam int unsigned OFS_MODE = 32'h60;
  localparam int unsigned OFS_CLR  = 32'h70;
  localparam int unsigned PORT_STEP = 4;

  typedef enum logic [1:0] {
    LANE_POL  = 2'd0,
    LANE_EDGE = 2'd1,
    LANE_BOTH = 2'd2,
    LANE_NONE = 2'd3
  } lane_e;
endpackage

// File: rtl/gpirq_trig.sv
module gpirq_trig (
  input  logic pin_now,
  input  logic pin_old,
  input  logic pol,
  input  logic edg,
  input  logic both,
  output logic hit
);
  logic rise, fall;
  assign rise = pin_now & ~pin_old;
  assign fall = ~pin_now & pin_old;

  always_comb begin
    if (edg) begin
      if (both) hit = rise | fall;
      else      hit = pol ? rise : fall;
    end else begin
      hit = pol ? pin_now : ~pin_now;
    end
  end
endmodule

// File: rtl/gpirq_detect.sv
module gpirq_detect #(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   pins,
  input  logic [3*NPIN-1:0] mode,
  input  logic [NPIN-1:0]   clr,
  output logic [NPIN-1:0]   set_o,
  output logic [NPIN-1:0]   stat_o
);
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] stat_q;

  always_ff @(posedge clk) prev_q <= pins;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    gpirq_trig u_trig (
      .pin_now (pins[i]),
      .pin_old (prev_q[i]),
      .pol     (mode[i]),
      .edg     (mode[NPIN + i]),
      .both    (mode[2*NPIN + i]),
      .hit     (set_o[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr) | set_o;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gpirq_regs.sv
module gpirq_regs
  import gpirq_pkg::*;
#(
  parameter int NPIN     = 8,
  parameter int AW       = 8,
  parameter int PORT_IDX = 0,
  parameter int MASK_OFS = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [3*NPIN-1:0] wdata,
  input  logic [NPIN-1:0]   stat,
  output logic [NPIN-1:0]   enb_o,
  output logic [3*NPIN-1:0] mode_o,
  output logic [NPIN-1:0]   clr_o,
  output logic              mode_msk_hit_o,
  output logic [3*NPIN-1:0] rdata_o
);
  localparam int DW   = 3*NPIN;
  localparam int BASE = PORT_STEP * PORT_IDX;
  localparam logic [AW-1:0] A_STAT  = AW'(OFS_STAT + BASE);
  localparam logic [AW-1:0] A_ENB   = AW'(OFS_ENB  + BASE);
  localparam logic [AW-1:0] A_MODE  = AW'(OFS_MODE + BASE);
  localparam logic [AW-1:0] A_CLR   = AW'(OFS_CLR  + BASE);
  localparam logic [AW-1:0] A_ENBM  = AW'(OFS_ENB  + BASE + MASK_OFS);
  localparam logic [AW-1:0] A_MODEM = AW'(OFS_MODE + BASE + MASK_OFS);

  logic [NPIN-1:0] enb_q, enb_d;
  logic [DW-1:0]   mode_q, mode_d, rdata_q;
  logic [NPIN-1:0] m_val, m_msk;
  lane_e           lane;

  assign m_val = wdata[0 +: NPIN];
  assign m_msk = wdata[NPIN +: NPIN];
  assign lane  = lane_e'(wdata[2*NPIN +: 2]);

  always_comb begin
    enb_d = enb_q;
    if (wr_en && addr == A_ENB)       enb_d = m_val;
    else if (wr_en && addr == A_ENBM) enb_d = (enb_q & ~m_msk) | (m_val & m_msk);
  end

  always_comb begin
    mode_d = mode_q;
    if (wr_en && addr == A_MODE) begin
      mode_d = wdata;
    end else if (wr_en && addr == A_MODEM) begin
      for (int l = 0; l < 3; l++) begin
        if (lane == lane_e'(l))
          mode_d[l*NPIN +: NPIN] = (mode_q[l*NPIN +: NPIN] & ~m_msk) | (m_val & m_msk);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enb_q   <= '0;
      mode_q  <= '0;
      rdata_q <= '0;
    end else begin
      enb_q  <= enb_d;
      mode_q <= mode_d;
      case (addr)
        A_STAT:          rdata_q <= DW'(stat);
        A_ENB, A_ENBM:   rdata_q <= DW'(enb_q);
        A_MODE, A_MODEM: rdata_q <= mode_q;
        default:         rdata_q <= '0;
      endcase
    end
  end

  assign clr_o          = (wr_en && addr == A_CLR) ? m_val : '0;
  assign mode_msk_hit_o = wr_en && addr == A_MODEM;
  assign enb_o          = enb_q;
  assign mode_o         = mode_q;
  assign rdata_o        = rdata_q;
endmodule

// File: rtl/gpirq_top.sv
module gpirq_top #(
  parameter int NPIN     = 8,
  parameter int AW       = 8,
  parameter int PORT_IDX = 0,
  parameter int MASK_OFS = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   pins_in,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [3*NPIN-1:0] wdata,
  output logic [3*NPIN-1:0] rdata,
  output logic              irq
);
  logic [NPIN-1:0]   enb_q, stat_q, set_vec, clr_vec;
  logic [3*NPIN-1:0] mode_q;
  logic              mode_msk_hit;
  logic              irq_q;

  gpirq_regs #(
    .NPIN(NPIN), .AW(AW), .PORT_IDX(PORT_IDX), .MASK_OFS(MASK_OFS)
  ) u_regs (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .addr           (addr),
    .wdata          (wdata),
    .stat           (stat_q),
    .enb_o          (enb_q),
    .mode_o         (mode_q),
    .clr_o          (clr_vec),
    .mode_msk_hit_o (mode_msk_hit),
    .rdata_o        (rdata)
  );

  gpirq_detect #(.NPIN(NPIN)) u_detect (
    .clk    (clk),
    .rst    (rst),
    .pins   (pins_in),
    .mode   (mode_q),
    .clr    (clr_vec),
    .set_o  (set_vec),
    .stat_o (stat_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat_q & enb_q);
  end

  assign irq = irq_q;
endmodule

// File: rtl/gpirq_chk.sv
module gpirq_chk #(
  parameter int NPIN = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NPIN-1:0]   stat,
  input logic [NPIN-1:0]   enb,
  input logic [3*NPIN-1:0] mode,
  input logic [NPIN-1:0]   set_vec,
  input logic [NPIN-1:0]   clr_vec,
  input logic              mode_msk_hit,
  input logic [3*NPIN-1:0] wdata,
  input logic              irq
);
  // R1: reset empties the event bits and drops the interrupt
  a_r1_reset_clean: assert property (@(posedge clk)
    rst |=> (stat == '0 && !irq));

  // R7 and R8: every bit the detector raised is present next cycle
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat & $past(set_vec)) == $past(set_vec)));

  // R6: a cleared bit with no new trigger drops
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat & $past(clr_vec & ~set_vec)) == '0));

  // R6: bits neither set nor cleared hold their value
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat & ~$past(set_vec | clr_vec)) ==
              ($past(stat) & ~$past(set_vec | clr_vec))));

  // R9: interrupt follows the enabled events with one register
  a_r9_irq_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |$past(stat & enb)));

  // R11: lane code 3 in the masked trigger alias leaves the trigger unchanged
  a_r11_lane3_idle: assert property (@(posedge clk) disable iff (rst)
    (mode_msk_hit && wdata[2*NPIN +: 2] == 2'd3) |=> $stable(mode));
endmodule

bind gpirq_top gpirq_chk #(.NPIN(NPIN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .stat         (stat_q),
  .enb          (enb_q),
  .mode         (mode_q),
  .set_vec      (set_vec),
  .clr_vec      (clr_vec),
  .mode_msk_hit (mode_msk_hit),
  .wdata        (wdata),
  .irq          (irq)
);

// File: tb/tb_gpirq_top.sv
`timescale 1ns/1ps
module tb_gpirq_top;
  localparam int NPIN = 8;
  localparam int AW   = 8;
  localparam int PIDX = 1;
  localparam logic [7:0] A_STAT  = 8'h44;
  localparam logic [7:0] A_ENB   = 8'h54;
  localparam logic [7:0] A_MODE  = 8'h64;
  localparam logic [7:0] A_CLR   = 8'h74;
  localparam logic [7:0] A_ENBM  = 8'hD4;
  localparam logic [7:0] A_MODEM = 8'hE4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pins_in = 8'hFF;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [23:0] wdata = '0;
  logic [23:0] rdata;
  logic        irq;

  int nchk = 0;
  int nfail = 0;
  logic [23:0] rv;

  always #10 clk = ~clk;

  gpirq_top #(.NPIN(NPIN), .AW(AW), .PORT_IDX(PIDX)) dut (
    .clk(clk), .rst(rst), .pins_in(pins_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [23:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  function automatic logic [23:0] mode_word(input int m);
    case (m)
      0: return 24'h00FFFF;
      1: return 24'h00FF00;
      2: return 24'hFFFF00;
      3: return 24'h0000FF;
      default: return 24'h000000;
    endcase
  endfunction

  function automatic logic [7:0] exp_stat(input int m, input logic [7:0] a, input logic [7:0] b);
    case (m)
      0: return b & ~a;
      1: return a & ~b;
      2: return a ^ b;
      3: return a | b;
      default: return ~a | ~b;
    endcase
  endfunction

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R2 rising";
      1: return "R3 falling";
      2: return "R4 both";
      default: return "R5 level";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {23'd0, irq}, 24'd0);
    rd(A_ENB, rv);  check("R1 enable", rv, 24'd0);
    rd(A_MODE, rv); check("R1 trigger", rv, 24'd0);
    rd(A_STAT, rv); check("R1 events", rv, 24'd0);

    // R5/R8 level low with enables off
    @(negedge clk); pins_in = 8'h0F;
    rd(A_STAT, rv); check("R8 events without enable", rv, 24'h0000F0);
    check("R8 irq gated", {23'd0, irq}, 24'd0);
    wr(A_CLR, 24'hFF);
    rd(A_STAT, rv); check("R5 clear while level active", rv, 24'h0000F0);
    @(negedge clk); pins_in = 8'hFF;
    wr(A_CLR, 24'hFF);
    rd(A_STAT, rv); check("R5 clear after level gone", rv, 24'h0);

    // Sweep of all trigger modes over transition patterns (R2-R5, R9)
    for (int m = 0; m < 5; m++) begin
      for (int t = 0; t < 16; t++) begin
        logic [7:0] p0, p1, en, ex;
        p0 = 8'(t*37 + m*11);
        p1 = 8'(t*91 + 5);
        en = 8'(t*29);
        @(negedge clk); pins_in = p0;
        wr(A_ENB, {16'd0, en});
        wr(A_MODE, mode_word(m));
        wr(A_CLR, 24'hFF);
        pins_in = p1;
        ex = (m >= 3) ? exp_stat(m, p0, p1) : exp_stat(m, p0, p1);
        rd(A_STAT, rv);
        check(mode_tag(m), rv, {16'd0, ex});
        check("R9 irq", {23'd0, irq}, {23'd0, |(ex & en)});
      end
    end

    // R7 edge coinciding with clear
    wr(A_MODE, 24'h00FFFF);
    @(negedge clk); pins_in = 8'h00;
    wr(A_CLR, 24'hFF);
    pins_in = 8'h03;
    rd(A_STAT, rv); check("R2 two rising edges", rv, 24'h03);
    @(negedge clk); pins_in = 8'h00;
    @(negedge clk);
    pins_in = 8'h01; wr_en = 1'b1; addr = A_CLR; wdata = 24'h03;
    @(negedge clk); wr_en = 1'b0;
    rd(A_STAT, rv); check("R7 edge beats clear", rv, 24'h01);

    // R6 zeros ignored, clear reads zero
    wr(A_CLR, 24'h00);
    rd(A_STAT, rv); check("R6 zero clear no effect", rv, 24'h01);
    rd(A_CLR, rv);  check("R6 clear reads zero", rv, 24'h0);

    // R12 event register read only
    wr(A_STAT, 24'hFF);
    rd(A_STAT, rv); check("R12 event write ignored", rv, 24'h01);

    // R10 masked enable
    wr(A_ENB, 24'h0F);
    wr(A_ENBM, 24'h00F0A5);
    rd(A_ENB, rv); check("R10 masked enable", rv, 24'hAF);

    // R11 masked trigger lanes
    wr(A_MODE, 24'h0);
    wr(A_MODEM, 24'h013CFF);
    rd(A_MODE, rv); check("R11 edge lane", rv, 24'h003C00);
    wr(A_MODEM, 24'h000F05);
    rd(A_MODE, rv); check("R11 polarity lane", rv, 24'h003C05);
    wr(A_MODEM, 24'h02F0FF);
    rd(A_MODE, rv); check("R11 both lane", rv, 24'hF03C05);
    wr(A_MODEM, 24'h03FFFF);
    rd(A_MODE, rv); check("R11 lane 3 ignored", rv, 24'hF03C05);
    rd(A_MODEM, rv); check("R12 alias readback", rv, 24'hF03C05);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule